// File: doc/BRIEF.md
# Two-Threshold Cross-Neighbourhood Cluster Compressor

This block reduces a stream of 9-bit detector samples to a short list of cluster candidates. The samples arrive one channel row at a time. Each row holds a programmable number of time samples, from 1 to 256. The block keeps the most recent channel rows in three rotating line buffers. For each matrix position it looks at a cross of five values: the centre, the samples just before and after it in time, and the samples at the same time in the channel above and the channel below. A position is reported only when the centre and its neighbours pass two programmable thresholds. The report is one word holding the channel index, the time index and the centre amplitude.

The decision for channel c is made while channel c+1 streams in. The incoming sample provides the lower neighbour directly. When the last channel of an event has been received, the block drops its upstream enable for a fixed drain window. During the first cycles of that window it flushes the last row, using an all-zero next row. Any neighbour beyond the matrix border counts as zero. The sample count and both thresholds are captured when an event starts and stay fixed until it ends.

Top module: `cluster2d_comp`

## Requirements
- R1: A synchronous active-high reset leaves `up_en` high and `out_valid` low, and clears the channel index, the time index and the drain counter, so the next accepted sample is channel 0, time 0.
- R2: A position is reported only when its centre is strictly greater than the high threshold and at least one of its four neighbours is strictly greater than the low threshold. A value equal to a threshold does not pass it.
- R3: A report sets `out_valid` for one cycle, with `out_ch` = channel (8 bits), `out_t` = time index (8 bits) and `out_amp` = the 9-bit centre sample.
- R4: A neighbour outside the matrix counts as zero: the left neighbour at time 0, the right neighbour at the last time index, and the upper neighbour for channel 0.
- R5: After the last sample of an event, the last channel row is evaluated with a zero lower neighbour during the drain window, one time index per cycle from 0 upward.
- R6: After the cycle that accepts the last sample of an event, `up_en` is low for exactly 256 cycles and then returns high.
- R7: Samples presented while `up_en` is low are ignored: they change neither the stored matrix nor the indices.
- R8: `cfg_last_t` (number of samples per channel minus one) and both thresholds are sampled on the first accepted sample of an event. Changes made during the event have no effect.
- R9: The report for position (c, t) appears in the cycle after sample (c+1, t) is accepted. Reports for a row come out in increasing time order.
- R10: Cycles with `in_valid` low neither advance the indices nor produce a report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present on `in_sample` |
| in_sample | input | 9 | Incoming detector sample |
| up_en | output | 1 | Upstream enable; a sample is accepted when this and `in_valid` are both high |
| cfg_last_t | input | 8 | Samples per channel minus one |
| cfg_thr_hi | input | 9 | Centre threshold |
| cfg_thr_lo | input | 9 | Neighbour threshold |
| out_valid | output | 1 | Report strobe |
| out_ch | output | 8 | Channel index of the reported centre |
| out_t | output | 8 | Time index of the reported centre |
| out_amp | output | 9 | Centre amplitude |

## Verification
The hardest case to reach is the flush of the final row while the configuration and the input are both changing. The stimulus runs a full-length 256-sample event, rewrites the thresholds and the sample count halfway through it, and then holds `in_valid` high with noise for the whole drain window. It also runs a one-sample-per-channel event. In that event every position touches both time borders, and the samples are placed exactly on and one above each threshold, with random gaps in `in_valid`. A behavioural matrix model in the bench predicts every output on every clock.

// File: rtl/cluster2d_pkg.sv
package cluster2d_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } cc_state_e;

   // rotate among three buffers
   function automatic logic [1:0] sel_next(input logic [1:0] s);
      return (s == 2'd2) ? 2'd0 : s + 2'd1;
   endfunction

   function automatic logic [1:0] sel_prev(input logic [1:0] s);
      return (s == 2'd0) ? 2'd2 : s - 2'd1;
   endfunction
endpackage

// File: rtl/cc_linebuf.sv
module cc_linebuf #(
   parameter int DEPTH = 256,
   parameter int W     = 9,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [W-1:0]  rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_b
);
   logic [W-1:0] mem [DEPTH];

   initial begin
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $error("cc_linebuf: DEPTH must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/cc_cross_eval.sv
module cc_cross_eval #(
   parameter int W = 9
) (
   input  logic [W-1:0]      centre,
   input  logic [3:0][W-1:0] nbr,
   input  logic [W-1:0]      thr_hi,
   input  logic [W-1:0]      thr_lo,
   output logic              hit
);
   logic [3:0] nbr_over;

   for (genvar i = 0; i < 4; i++) begin : g_nbr
      assign nbr_over[i] = nbr[i] > thr_lo;
   end

   assign hit = (centre > thr_hi) && (|nbr_over);
endmodule

// File: rtl/cc_seq_ctrl.sv
module cc_seq_ctrl
   import cluster2d_pkg::*;
#(
   parameter int NUM_CH    = 16,
   parameter int CH_W      = 8,
   parameter int T_W       = 8,
   parameter int W         = 9,
   parameter int DRAIN_CYC = 256,
   localparam int DC_W     = $clog2(DRAIN_CYC + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [T_W-1:0]  cfg_last_t,
   input  logic [W-1:0]    cfg_thr_hi,
   input  logic [W-1:0]    cfg_thr_lo,
   output logic            up_en,
   output logic            acc,
   output logic [1:0]      wsel,
   output logic [T_W-1:0]  wr_t,
   output logic            eval_en,
   output logic [CH_W-1:0] eval_ch,
   output logic [T_W-1:0]  rd_t,
   output logic            at_first_t,
   output logic            at_last_t,
   output logic            up_zero,
   output logic            dn_zero,
   output logic [T_W-1:0]  last_q,
   output logic [W-1:0]    hi_q,
   output logic [W-1:0]    lo_q
);
   localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CH - 1);
   localparam logic [DC_W-1:0] DC_LAST = DC_W'(DRAIN_CYC - 1);

   cc_state_e       state;
   logic [CH_W-1:0] ch_idx;
   logic [T_W-1:0]  t_idx;
   logic [T_W-1:0]  ft;
   logic            flush_on;
   logic [DC_W-1:0] dcnt;
   logic [T_W-1:0]  eff_last;
   logic            in_drain;

   assign in_drain   = (state == ST_DRAIN);
   assign up_en      = !in_drain;
   assign acc        = in_valid && up_en;
   assign eff_last   = (state == ST_IDLE) ? cfg_last_t : last_q;
   assign wr_t       = t_idx;
   assign rd_t       = in_drain ? ft : t_idx;
   assign eval_en    = in_drain ? flush_on : (acc && ch_idx != '0);
   assign eval_ch    = in_drain ? CH_LAST : ch_idx - CH_W'(1);
   assign at_first_t = (rd_t == '0);
   assign at_last_t  = (rd_t == eff_last);
   assign up_zero    = !in_drain && (ch_idx == CH_W'(1));
   assign dn_zero    = in_drain;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         ch_idx   <= '0;
         t_idx    <= '0;
         ft       <= '0;
         flush_on <= 1'b0;
         dcnt     <= '0;
         wsel     <= 2'd0;
         last_q   <= '0;
         hi_q     <= '0;
         lo_q     <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_RUN: begin
               if (acc) begin
                  if (state == ST_IDLE) begin
                     last_q <= cfg_last_t;
                     hi_q   <= cfg_thr_hi;
                     lo_q   <= cfg_thr_lo;
                     state  <= ST_RUN;
                  end
                  if (t_idx == eff_last) begin
                     t_idx <= '0;
                     wsel  <= sel_next(wsel);
                     if (ch_idx == CH_LAST) begin
                        state    <= ST_DRAIN;
                        ch_idx   <= '0;
                        dcnt     <= '0;
                        flush_on <= 1'b1;
                        ft       <= '0;
                     end else begin
                        ch_idx <= ch_idx + CH_W'(1);
                     end
                  end else begin
                     t_idx <= t_idx + T_W'(1);
                  end
               end
            end
            ST_DRAIN: begin
               if (flush_on) begin
                  if (ft == last_q) flush_on <= 1'b0;
                  else              ft <= ft + T_W'(1);
               end
               if (dcnt == DC_LAST) begin
                  state <= ST_IDLE;
                  dcnt  <= '0;
               end else begin
                  dcnt <= dcnt + DC_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R7
   ign_drain_chk: assert property (@(posedge clk) disable iff (rst)
      (!up_en && in_valid) |=> ($stable(t_idx) && $stable(ch_idx)));

   // R5
   flush_in_drain_chk: assert property (@(posedge clk) disable iff (rst)
      flush_on |-> !up_en);

   // R6
   drain_len_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(up_en) |-> ($past(dcnt) == DC_LAST));

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (up_en && !in_valid) |=> ($stable(t_idx) && $stable(ch_idx)));
endmodule

// File: rtl/cluster2d_comp.sv
module cluster2d_comp
   import cluster2d_pkg::*;
#(
   parameter int NUM_CH    = 16,
   parameter int MAX_T     = 256,
   parameter int SAMP_W    = 9,
   parameter int CH_W      = 8,
   parameter int DRAIN_CYC = 256,
   localparam int T_W      = $clog2(MAX_T)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [SAMP_W-1:0] in_sample,
   output logic              up_en,
   input  logic [T_W-1:0]    cfg_last_t,
   input  logic [SAMP_W-1:0] cfg_thr_hi,
   input  logic [SAMP_W-1:0] cfg_thr_lo,
   output logic              out_valid,
   output logic [CH_W-1:0]   out_ch,
   output logic [T_W-1:0]    out_t,
   output logic [SAMP_W-1:0] out_amp
);
   initial begin
      assert (NUM_CH >= 2 && NUM_CH <= (1 << CH_W))
         else $error("cluster2d_comp: NUM_CH out of range");
      assert (DRAIN_CYC >= MAX_T)
         else $error("cluster2d_comp: drain window shorter than flush");
   end

   logic              acc, eval_en, at_first_t, at_last_t, up_zero, dn_zero;
   logic [1:0]        wsel, msel, psel;
   logic [T_W-1:0]    wr_t, rd_t, last_q;
   logic [CH_W-1:0]   eval_ch;
   logic [SAMP_W-1:0] hi_q, lo_q;

   cc_seq_ctrl #(
      .NUM_CH(NUM_CH), .CH_W(CH_W), .T_W(T_W),
      .W(SAMP_W), .DRAIN_CYC(DRAIN_CYC)
   ) ctrl_i (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .cfg_last_t(cfg_last_t), .cfg_thr_hi(cfg_thr_hi), .cfg_thr_lo(cfg_thr_lo),
      .up_en(up_en), .acc(acc), .wsel(wsel), .wr_t(wr_t),
      .eval_en(eval_en), .eval_ch(eval_ch), .rd_t(rd_t),
      .at_first_t(at_first_t), .at_last_t(at_last_t),
      .up_zero(up_zero), .dn_zero(dn_zero),
      .last_q(last_q), .hi_q(hi_q), .lo_q(lo_q)
   );

   assign msel = sel_prev(wsel);
   assign psel = sel_prev(msel);

   // three rotating row buffers, two read ports each
   logic [SAMP_W-1:0] rd_a [3];
   logic [SAMP_W-1:0] rd_b [3];
   logic [T_W-1:0]    rd_t_nx;
   assign rd_t_nx = rd_t + T_W'(1);

   for (genvar b = 0; b < 3; b++) begin : g_row
      cc_linebuf #(.DEPTH(MAX_T), .W(SAMP_W)) buf_i (
         .clk(clk),
         .we(acc && wsel == 2'(b)),
         .waddr(wr_t),
         .wdata(in_sample),
         .raddr_a(rd_t),
         .rdata_a(rd_a[b]),
         .raddr_b(rd_t_nx),
         .rdata_b(rd_b[b])
      );
   end

   logic [SAMP_W-1:0] centre, left_q;
   logic [3:0][SAMP_W-1:0] nbr;
   logic              hit;

   assign centre = rd_a[msel];
   assign nbr[0] = at_first_t ? '0 : left_q;
   assign nbr[1] = at_last_t  ? '0 : rd_b[msel];
   assign nbr[2] = up_zero    ? '0 : rd_a[psel];
   assign nbr[3] = dn_zero    ? '0 : in_sample;

   cc_cross_eval #(.W(SAMP_W)) eval_i (
      .centre(centre), .nbr(nbr), .thr_hi(hi_q), .thr_lo(lo_q), .hit(hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         left_q    <= '0;
         out_valid <= 1'b0;
         out_ch    <= '0;
         out_t     <= '0;
         out_amp   <= '0;
      end else begin
         if (eval_en) left_q <= centre;
         out_valid <= eval_en && hit;
         if (eval_en && hit) begin
            out_ch  <= eval_ch;
            out_t   <= rd_t;
            out_amp <= centre;
         end
      end
   end

   // R2
   amp_over_hi_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_amp > hi_q));

   // R3
   t_in_range_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_t <= last_q));

   // R3
   ch_in_range_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_ch < CH_W'(NUM_CH)));
endmodule

// File: tb/cluster2d_comp_tb_top.sv
module cluster2d_comp_tb_top;
   localparam int NCH   = 16;
   localparam int DRAIN = 256;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [8:0] in_sample = '0;
   logic [7:0] cfg_last_t = '0;
   logic [8:0] cfg_thr_hi = '0;
   logic [8:0] cfg_thr_lo = '0;
   logic       up_en, out_valid;
   logic [7:0] out_ch, out_t;
   logic [8:0] out_amp;

   always #4 clk = ~clk;

   cluster2d_comp dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .up_en(up_en), .cfg_last_t(cfg_last_t), .cfg_thr_hi(cfg_thr_hi),
      .cfg_thr_lo(cfg_thr_lo), .out_valid(out_valid), .out_ch(out_ch),
      .out_t(out_t), .out_amp(out_amp)
   );

   int    n_chk = 0, n_fail = 0, cyc = 0;
   string tag = "R1";

   // behavioural model
   int mat [NCH][256];
   int ms = 0, mc = 0, mt = 0, mft = 0, mdc = 0, m_last = 0, m_hi = 0, m_lo = 0;
   bit mflush = 0;
   bit e_valid = 0, e_up = 1;
   int e_ch = 0, e_t = 0, e_amp = 0;

   task automatic model_eval(input int c, input int t, input int nx);
      int ctr, up, lf, rt;
      ctr = mat[c][t];
      up  = (c > 0) ? mat[c-1][t] : 0;
      lf  = (t > 0) ? mat[c][t-1] : 0;
      rt  = (t < m_last) ? mat[c][t+1] : 0;
      if (ctr > m_hi && (up > m_lo || lf > m_lo || rt > m_lo || nx > m_lo)) begin
         e_valid = 1; e_ch = c; e_t = t; e_amp = ctr;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         ms = 0; mc = 0; mt = 0; mft = 0; mdc = 0; mflush = 0;
         e_valid = 0; e_up = 1;
      end else begin
         e_valid = 0;
         if (ms != 2) begin
            if (in_valid) begin
               if (ms == 0) begin
                  m_last = cfg_last_t; m_hi = cfg_thr_hi; m_lo = cfg_thr_lo; ms = 1;
               end
               mat[mc][mt] = in_sample;
               if (mc > 0) model_eval(mc - 1, mt, in_sample);
               if (mt == m_last) begin
                  mt = 0;
                  if (mc == NCH - 1) begin
                     ms = 2; mc = 0; mdc = 0; mflush = 1; mft = 0;
                  end else mc++;
               end else mt++;
            end
         end else begin
            if (mflush) begin
               model_eval(NCH - 1, mft, 0);
               if (mft == m_last) mflush = 0; else mft++;
            end
            if (mdc == DRAIN - 1) begin ms = 0; mdc = 0; end else mdc++;
         end
         e_up = (ms != 2);
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0d exp=%0d at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         chk("up_en (R6 R7)", int'(up_en), int'(e_up));
         chk("out_valid (R2 R9)", int'(out_valid), int'(e_valid));
         if (e_valid) begin
            chk("out_ch (R3)", int'(out_ch), e_ch);
            chk("out_t (R3)", int'(out_t), e_t);
            chk("out_amp (R3)", int'(out_amp), e_amp);
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   function automatic logic [8:0] gen_sample(input int kind);
      int r;
      r = $urandom % 4;
      if (kind == 1) begin
         // values on and one above thresholds hi=200 lo=40
         case (r)
            0: return 9'd200;
            1: return 9'd201;
            2: return 9'd40;
            default: return 9'd41;
         endcase
      end
      if (r == 0) return 9'(60 + $urandom % 452);
      return 9'($urandom % 70);
   endfunction

   // kind: 0 random, 1 threshold boundary; gaps: random idle cycles (R10);
   // midchg: rewrite config halfway (R8); noise: drive during drain (R7)
   task automatic run_event(input int last, input int hi, input int lo,
                            input int kind, input bit gaps, input bit midchg,
                            input bit noise);
      int total, sent;
      total = NCH * (last + 1);
      sent  = 0;
      @(negedge clk); #1;
      cfg_last_t = 8'(last); cfg_thr_hi = 9'(hi); cfg_thr_lo = 9'(lo);
      while (sent < total) begin
         if (gaps && ($urandom % 3 == 0)) begin
            in_valid = 1'b0;
            in_sample = 9'($urandom % 512);
         end else begin
            in_valid  = 1'b1;
            in_sample = gen_sample(kind);
            sent++;
         end
         if (midchg && sent == total / 2) begin
            cfg_last_t = 8'd3; cfg_thr_hi = 9'd5; cfg_thr_lo = 9'd0;
         end
         @(negedge clk); #1;
      end
      in_valid = 1'b0;
      // drain window: up_en already low here
      while (!up_en) begin
         in_valid  = noise;
         in_sample = 9'(300 + $urandom % 200);
         @(negedge clk); #1;
      end
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk); #1;
      rst = 1'b0;
      @(negedge clk);
      tag = "R1";
      chk("reset up_en R1", int'(up_en), 1);
      chk("reset out_valid R1", int'(out_valid), 0);

      tag = "R2 R4 R9";
      run_event(7, 100, 40, 0, 1'b0, 1'b0, 1'b0);

      tag = "R2 R4 R10";
      run_event(0, 200, 40, 1, 1'b1, 1'b0, 1'b0);

      tag = "R5 R7 R8";
      run_event(255, 150, 50, 0, 1'b0, 1'b1, 1'b1);

      tag = "R2 R10";
      run_event(12, 200, 40, 1, 1'b1, 1'b0, 1'b1);

      // mid-event reset returns indices to channel 0, time 0
      tag = "R1";
      @(negedge clk); #1;
      cfg_last_t = 8'd5; cfg_thr_hi = 9'd80; cfg_thr_lo = 9'd20;
      in_valid = 1'b1; in_sample = 9'd90;
      repeat (9) @(negedge clk);
      #1 rst = 1'b1; in_valid = 1'b0;
      @(negedge clk); #1 rst = 1'b0;
      @(negedge clk);
      chk("post-reset up_en R1", int'(up_en), 1);
      tag = "R1 R4 R9";
      run_event(5, 80, 20, 0, 1'b0, 1'b0, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule